// File: doc/BRIEF.md
# VLIW Bundle Operation Router

The router takes one long instruction word at a time from the fetch side and splits it into 32-bit operation slots. It then steers each slot to one of five functional-unit ports: integer unit 0, integer unit 1, floating point, load/store and branch. No scheduling or dependency analysis is done. A 2-bit format field and a length bit, both carried in the lowest slot, fully fix which slot goes to which unit. A short word holds two slots. A long word holds four slots and fills the full 128-bit input.

Words issue strictly in order. A word leaves only when every unit it targets asserts ready, and then all of its operations leave in the same cycle. A word is never partly issued. A word whose mapping sends two operations to the same single-instance unit is malformed. It is accepted and dropped, and an error pulse marks it. The router sits between the fetch handshake and the unit ports with no storage on the data path.

Unit index k uses bits [32k+31:32k] of `unit_op` and bit k of `unit_valid` and `unit_ready`. The indices are: 0 = integer 0, 1 = integer 1, 2 = floating point, 3 = load/store, 4 = branch.

Top module: `vliw_router`

## Requirements
- R1: After reset, `err_o` is 0.
- R2: Slot s occupies `in_word[32s+31:32s]`. Bit 29 of slot 0 selects the length: 0 means a short word, in which only slots 0 and 1 are active, and 1 means a long word, in which slots 0 to 3 are active. An inactive slot drives no unit and causes no stall.
- R3: Bits [31:30] of slot 0 choose the format. The targets of slots 0..3 are: format 0 → 0,1,3,4; format 1 → 0,2,3,4; format 2 → 0,1,2,4; format 3 → 0,1,3,3.
- R4: When a unit's valid is high, its `unit_op` field carries the exact 32-bit slot routed to it.
- R5: If any unit targeted by an active slot has ready low, then every `unit_valid` bit is 0 and `in_ready` is 0.
- R6: If all targeted units are ready, then `in_ready` is 1, and while `in_valid` is high exactly the targeted units see valid. The ready of a unit that is not targeted has no effect.
- R7: A long word in format 3 targets load/store twice and is malformed. For such a word `in_ready` is 1 and no `unit_valid` bit rises. `err_o` is 1 in the cycle after the word is accepted, and only then.
- R8: While `in_valid` is 0, no `unit_valid` bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Fetch side offers a word |
| in_ready | output | 1 | Word is taken this cycle |
| in_word | input | 128 | Instruction word, slot 0 in the low bits |
| unit_ready | input | 5 | Per-unit ready |
| unit_valid | output | 5 | Per-unit operation valid |
| unit_op | output | 160 | Per-unit operation, 32 bits per unit |
| err_o | output | 1 | One-cycle pulse after a malformed word is dropped |

## Verification
The bench sweeps every format, both lengths and all 32 ready patterns. It goes after the corners where a wrong design shows visible symptoms. A short word that counts slots 2 and 3 would stall on the ready of a unit it never uses, or raise valid on that unit. A router that issues per unit instead of per word would raise some valids while another targeted unit is stalled. A design that misses the duplicate load/store target would pass a malformed word to the units, and a design that blocks on it would hang the fetch side. The bench also sweeps the slot payloads, so a mis-wired slot shows up as a wrong operation on the unit port.

// File: rtl/vliw_router.sv
module vliw_router #(
  parameter int SLOT_W = 32,
  parameter int NSLOT  = 4,
  parameter int NUNIT  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [NSLOT*SLOT_W-1:0] in_word,
  input  logic [NUNIT-1:0]        unit_ready,
  output logic [NUNIT-1:0]        unit_valid,
  output logic [NUNIT*SLOT_W-1:0] unit_op,
  output logic                    err_o
);
  localparam int SHORT_SLOTS = NSLOT / 2;

  function automatic int target(logic [1:0] f, int s);
    case (f)
      2'd0:    target = (s == 0) ? 0 : (s == 1) ? 1 : (s == 2) ? 3 : 4;
      2'd1:    target = (s == 0) ? 0 : (s == 1) ? 2 : (s == 2) ? 3 : 4;
      2'd2:    target = (s == 0) ? 0 : (s == 1) ? 1 : (s == 2) ? 2 : 4;
      default: target = (s == 0) ? 0 : (s == 1) ? 1 : 3;
    endcase
  endfunction

  wire [1:0] fmt      = in_word[SLOT_W-1 -: 2];
  wire       long_w   = in_word[SLOT_W-3];
  logic [NUNIT-1:0] need;
  logic             conflict;

  always_comb begin
    need     = '0;
    conflict = 1'b0;
    unit_op  = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (s < SHORT_SLOTS || long_w) begin
        int t;
        t = target(fmt, s);
        if (need[t] && t > 1) conflict = 1'b1;
        need[t] = 1'b1;
        unit_op[t*SLOT_W +: SLOT_W] = in_word[s*SLOT_W +: SLOT_W];
      end
    end
  end

  wire all_ready = ((need & ~unit_ready) == '0);
  assign in_ready   = conflict || all_ready;
  assign unit_valid = (in_valid && !conflict && all_ready) ? need : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) err_o <= 1'b0;
    else        err_o <= in_valid && conflict;

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> unit_valid == '0);
  a_r5_whole_or_none: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_valid != '0) |-> (in_ready && (unit_valid & ~unit_ready) == '0));
  a_r2_short_two: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !long_w) |-> $countones(unit_valid) <= 2);
  a_r7_err_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && unit_valid == '0) |=> (err_o || $past(all_ready && !conflict)));
  a_r7_err_onecycle: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(in_valid && in_ready));
endmodule

// File: tb/sim_vliw_router.sv
module sim_vliw_router;
  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [127:0] in_word = '0;
  logic [4:0] unit_ready = '0;
  wire in_ready, err_o;
  wire [4:0] unit_valid;
  wire [159:0] unit_op;
  int checks = 0, errors = 0;

  vliw_router u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .unit_ready(unit_ready), .unit_valid(unit_valid),
    .unit_op(unit_op), .err_o(err_o));

  always #5 clk = ~clk;

  function automatic int tgt(int f, int s);
    int m [4][4] = '{'{0,1,3,4}, '{0,2,3,4}, '{0,1,2,4}, '{0,1,3,3}};
    return m[f][s];
  endfunction

  task automatic chk(string r, logic [159:0] a, logic [159:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual %h expected %h", r, a, e);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual hang expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1", {159'd0, err_o}, 0);
    rst_n = 1;
    for (int f = 0; f < 4; f++)
      for (int l = 0; l < 2; l++)
        for (int rp = 0; rp < 32; rp++) begin
          logic [4:0] need, ev;
          logic [31:0] sl [4];
          logic bad, er;
          need = 0;
          for (int s = 0; s < 4; s++) begin
            sl[s] = 32'h1357_9BDF * (s + 1) + 32'(rp * 977 + f * 31 + l);
            if (s == 0) sl[s][31:29] = {f[1:0], l[0]};
            if (s < 2 || l == 1) need[tgt(f, s)] = 1;
          end
          bad = (f == 3 && l == 1);
          er  = bad || ((need & ~rp[4:0]) == 0);
          ev  = (!bad && er) ? need : 5'd0;
          @(negedge clk);
          in_word = {sl[3], sl[2], sl[1], sl[0]};
          unit_ready = rp[4:0];
          in_valid = 0;
          #2;
          chk("R8", {155'd0, unit_valid}, 0);
          in_valid = 1;
          #2;
          chk(bad ? "R7" : (er ? "R6" : "R5"), {159'd0, in_ready}, {159'd0, er});
          chk(l ? "R3" : "R2", {155'd0, unit_valid}, {155'd0, ev});
          for (int s = 0; s < 4; s++)
            if ((s < 2 || l == 1) && ev[tgt(f, s)])
              chk("R4", {128'd0, unit_op[tgt(f, s)*32 +: 32]}, {128'd0, sl[s]});
          @(negedge clk);
          in_valid = 0;
          #2;
          chk("R7", {159'd0, err_o}, {159'd0, bad});
        end
    @(negedge clk);
    #2;
    chk("R7", {159'd0, err_o}, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule